// File: doc/BRIEF.md
# I2C Serial EEPROM Slave Front-End

This block is the bus side of a 2048-byte serial EEPROM. A fast system clock oversamples the two-wire bus lines. From these samples the block finds START and STOP conditions and takes in bytes on SCL rising edges. It answers each byte with an acknowledge on an open-drain SDA enable. The storage array and the page buffer sit outside the block. Reads come from the array through a combinational data input addressed by `mem_addr`. Accepted write bytes go to the page buffer one at a time. A STOP then asks the array to commit the buffer.

The device-select byte does two jobs. Its upper nibble must match the device code. Its next three bits supply the top memory-address bits, and its last bit picks the direction. A write session loads the word address and then one or more data bytes. The low four address bits wrap inside a 16-byte page. A read session shifts bytes out from the current address, and the address advances after each byte. After a committed write, the block stays busy for a set number of clocks. While busy it refuses its own address, so the master can poll until the write is done. The write-protect pin is strobed once per session, just before the first data byte.

Top module: `eep_i2c_slave`

## Requirements
- R1: An SDA fall while SCL is high is a START, and an SDA rise while SCL is high is a STOP. Until a START arrives, clocked bits get no acknowledge.
- R2: A device byte is accepted only if bits 7..4 equal 4'b1010. Bits 3..1 load address bits 10..8, and bit 0 selects read (1) or write (0).
- R3: An acknowledge is `sda_oe`=1 (SDA pulled low) for the whole 9th clock after an accepted byte. A refused byte leaves `sda_oe`=0, and the line reads 1. After reset `sda_oe` is 0.
- R4: Input bits are taken MSB first on SCL rising edges. `sda_oe` changes only in the cycle after an SCL falling edge, a START or a STOP.
- R5: In a write session, the device byte, the address byte and each data byte are acknowledged. Every accepted data byte pulses `pbuf_we` with its address and value. A STOP after at least one accepted data byte pulses `wr_commit` once.
- R6: `wp_i` is sampled on the SCL fall that ends the acknowledge of the address byte. If it was high, the first data byte gets no acknowledge and nothing is written. A later change of `wp_i` in the same session has no effect.
- R7: The cycle after `wr_commit`, `busy` rises and stays high for WR_CYCLES clocks. While it is high, every device byte gets no acknowledge.
- R8: A read sends the byte at `mem_addr` MSB first. A 1 bit releases SDA and a 0 bit pulls it low.
- R9: After each byte that is read, the address goes up by one. A master acknowledge starts the next byte. A master no-acknowledge releases the bus until the next START.
- R10: The read address wraps from 0x7FF to 0x000.
- R11: No commit follows a session that ends before any data byte was accepted. A START that interrupts a session holding accepted data pulses `pbuf_clr` and starts no write cycle.
- R12: During a write, the low four address bits wrap within the 16-byte page, and the upper bits stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level |
| wp_i | input | 1 | Write-protect level |
| sda_oe | output | 1 | 1 pulls SDA low |
| mem_addr | output | 11 | Current address, used for reads |
| mem_rdata | input | 8 | Array byte at `mem_addr` |
| pbuf_we | output | 1 | Page-buffer byte write strobe |
| pbuf_addr | output | 11 | Address of the strobed byte |
| pbuf_wdata | output | 8 | Value of the strobed byte |
| pbuf_clr | output | 1 | Drop the staged page-buffer contents |
| wr_commit | output | 1 | Commit the page buffer to the array |
| busy | output | 1 | Internal write cycle running |

## Verification
The hardest case to reach is the refused device byte during the write cycle. It exists only in the window after a STOP has committed data. The bench shortens WR_CYCLES, polls right after the STOP and expects a no-acknowledge, then polls until it gets an acknowledge. The second hard case is the write-protect strobe at one exact edge. The bench raises `wp_i` before the address acknowledge ends in one session and only after the first data byte in another, then reads back both places.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_ADDR,
    ST_WDATA,
    ST_RD
  } eep_state_e;

  localparam logic [3:0] EEP_DEV_CODE = 4'b1010;
endpackage

// File: rtl/eep_bus_sync.sv
module eep_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt,
  output logic sda_lvl
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q, scl_s, sda_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_s;
      sda_q    <= sda_s;
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign sda_lvl   = sda_s;
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/eep_wcycle.sv
module eep_wcycle #(
  parameter int WR_CYCLES = 250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  output logic busy
);
  localparam int CW = $clog2(WR_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(WR_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (go) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      if (cnt == LAST) busy <= 1'b0;
      else             cnt  <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/eep_i2c_slave.sv
module eep_i2c_slave
  import eep_pkg::*;
#(
  parameter int          ADDR_W      = 11,
  parameter int          PAGE_W      = 4,
  parameter int          WR_CYCLES   = 250000,
  parameter int          SYNC_STAGES = 2,
  parameter logic [3:0]  DEV_CODE    = EEP_DEV_CODE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              wp_i,
  output logic              sda_oe,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata,
  output logic              pbuf_we,
  output logic [ADDR_W-1:0] pbuf_addr,
  output logic [7:0]        pbuf_wdata,
  output logic              pbuf_clr,
  output logic              wr_commit,
  output logic              busy
);
  localparam int HI_W = ADDR_W - 8;
  localparam logic [3:0] ACK_BIT = 4'd8;

  function automatic logic [ADDR_W-1:0] page_next(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:PAGE_W], a[PAGE_W-1:0] + 1'b1};
  endfunction

  function automatic logic [ADDR_W-1:0] read_next(input logic [ADDR_W-1:0] a);
    return a + 1'b1;
  endfunction

  function automatic logic dev_hit(input logic [7:0] b);
    return b[7:4] == DEV_CODE;
  endfunction

  logic scl_rise, scl_fall, start_evt, stop_evt, sda_lvl;

  eep_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt), .sda_lvl(sda_lvl)
  );

  eep_wcycle #(.WR_CYCLES(WR_CYCLES)) u_wcyc (
    .clk(clk), .rst_n(rst_n), .go(wr_commit), .busy(busy)
  );

  eep_state_e        st, nxt;
  logic [3:0]        cnt;
  logic              ackph;
  logic [7:0]        sh, tx;
  logic [ADDR_W-1:0] addr;
  logic              wp_lat, first_d, have_data;

  assign mem_addr = addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      nxt        <= ST_IDLE;
      cnt        <= '0;
      ackph      <= 1'b0;
      sh         <= '0;
      tx         <= '0;
      addr       <= '0;
      wp_lat     <= 1'b0;
      first_d    <= 1'b0;
      have_data  <= 1'b0;
      sda_oe     <= 1'b0;
      pbuf_we    <= 1'b0;
      pbuf_addr  <= '0;
      pbuf_wdata <= '0;
      pbuf_clr   <= 1'b0;
      wr_commit  <= 1'b0;
    end else begin
      pbuf_we   <= 1'b0;
      pbuf_clr  <= 1'b0;
      wr_commit <= 1'b0;
      if (start_evt) begin
        st        <= ST_DEV;
        cnt       <= '0;
        ackph     <= 1'b0;
        sda_oe    <= 1'b0;
        pbuf_clr  <= have_data;
        have_data <= 1'b0;
      end else if (stop_evt) begin
        st        <= ST_IDLE;
        ackph     <= 1'b0;
        sda_oe    <= 1'b0;
        wr_commit <= have_data;
        have_data <= 1'b0;
      end else if (st == ST_RD) begin
        if (scl_rise) begin
          if (cnt != ACK_BIT) cnt <= cnt + 1'b1;
          else begin
            addr <= read_next(addr);
            if (sda_lvl) st  <= ST_IDLE;
            else         cnt <= '0;
          end
        end else if (scl_fall) begin
          if (cnt == 4'd0) begin
            tx     <= mem_rdata;
            sda_oe <= ~mem_rdata[7];
          end else if (cnt < ACK_BIT) begin
            sda_oe <= ~tx[3'(4'd7 - cnt)];
          end else begin
            sda_oe <= 1'b0;
          end
        end
      end else if (st != ST_IDLE) begin
        if (scl_rise && !ackph && cnt != ACK_BIT) begin
          sh  <= {sh[6:0], sda_lvl};
          cnt <= cnt + 1'b1;
        end else if (scl_fall && ackph) begin
          sda_oe <= 1'b0;
          ackph  <= 1'b0;
          cnt    <= '0;
          st     <= nxt;
          if (st == ST_ADDR) wp_lat <= wp_i;
          if (nxt == ST_RD) begin
            tx     <= mem_rdata;
            sda_oe <= ~mem_rdata[7];
          end
        end else if (scl_fall && cnt == ACK_BIT) begin
          case (st)
            ST_DEV: begin
              if (dev_hit(sh) && !busy) begin
                addr[ADDR_W-1:8] <= sh[HI_W:1];
                nxt    <= sh[0] ? ST_RD : ST_ADDR;
                sda_oe <= 1'b1;
                ackph  <= 1'b1;
              end else begin
                st <= ST_IDLE;
              end
            end
            ST_ADDR: begin
              addr[7:0] <= sh;
              nxt       <= ST_WDATA;
              first_d   <= 1'b1;
              sda_oe    <= 1'b1;
              ackph     <= 1'b1;
            end
            ST_WDATA: begin
              if (first_d && wp_lat) begin
                st <= ST_IDLE;
              end else begin
                pbuf_we    <= 1'b1;
                pbuf_addr  <= addr;
                pbuf_wdata <= sh;
                addr       <= page_next(addr);
                have_data  <= 1'b1;
                first_d    <= 1'b0;
                nxt        <= ST_WDATA;
                sda_oe     <= 1'b1;
                ackph      <= 1'b1;
              end
            end
            default: st <= ST_IDLE;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/eep_i2c_chk.sv
module eep_i2c_chk (
  input logic clk,
  input logic rst_n,
  input logic sda_oe,
  input logic busy,
  input logic wr_commit,
  input logic pbuf_we,
  input logic scl_fall,
  input logic start_evt,
  input logic stop_evt
);
  // R7
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_oe);

  // R7
  busy_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_commit));

  // R5
  commit_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> $past(stop_evt));

  // R4
  oe_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> $past(scl_fall || start_evt || stop_evt));

  // R7
  stage_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pbuf_we |-> !busy);
endmodule

bind eep_i2c_slave eep_i2c_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .busy(busy),
  .wr_commit(wr_commit), .pbuf_we(pbuf_we), .scl_fall(scl_fall),
  .start_evt(start_evt), .stop_evt(stop_evt)
);

// File: tb/tb_eep_i2c_slave.sv
module tb_eep_i2c_slave;
  localparam int H = 8;
  localparam int WR = 400;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1, wp = 1'b0;
  logic sda_oe, pbuf_we, pbuf_clr, wr_commit, busy;
  logic [10:0] mem_addr, pbuf_addr;
  logic [7:0] mem_rdata, pbuf_wdata;
  logic sda_line;
  assign sda_line = sda_m & ~sda_oe;

  logic [7:0] mem [0:2047];
  assign mem_rdata = mem[mem_addr];

  eep_i2c_slave #(.WR_CYCLES(WR)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .wp_i(wp),
    .sda_oe(sda_oe), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .pbuf_we(pbuf_we), .pbuf_addr(pbuf_addr), .pbuf_wdata(pbuf_wdata),
    .pbuf_clr(pbuf_clr), .wr_commit(wr_commit), .busy(busy)
  );

  int stg_a[$];
  logic [7:0] stg_d[$];
  always @(posedge clk) begin
    if (pbuf_we) begin stg_a.push_back(int'(pbuf_addr)); stg_d.push_back(pbuf_wdata); end
    if (pbuf_clr) begin stg_a.delete(); stg_d.delete(); end
    if (wr_commit) begin
      foreach (stg_a[i]) mem[stg_a[i]] = stg_d[i];
      stg_a.delete(); stg_d.delete();
    end
  end

  int checks = 0, fails = 0;
  typedef struct { string tag; logic [7:0] val; } item_t;
  item_t exp_q[$];
  logic [7:0] obs_q[$];

  always @(negedge clk) begin
    while (obs_q.size() > 0) begin
      logic [7:0] got;
      item_t e;
      got = obs_q.pop_front();
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL scoreboard: unexpected result %02h, nothing expected", got);
      end else begin
        e = exp_q.pop_front();
        if (got !== e.val) begin
          fails++;
          $display("FAIL %s: got %02h expected %02h", e.tag, got, e.val);
        end
      end
    end
  end

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic waitc(int n);
    repeat (n) @(posedge clk);
    #3;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; waitc(H); scl = 1'b1; waitc(H); sda_m = 1'b0; waitc(H); scl = 1'b0;
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; waitc(H); scl = 1'b1; waitc(H); sda_m = 1'b1; waitc(H);
  endtask

  task automatic clk_bit(input logic b, output logic s);
    sda_m = b; waitc(H); scl = 1'b1; waitc(H/2); s = sda_line; waitc(H/2); scl = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, ack);
  endtask

  task automatic wbx(string tag, logic [7:0] b, logic exp_ack);
    logic a;
    exp_q.push_back('{tag, {7'd0, exp_ack}});
    send_byte(b, a);
    obs_q.push_back({7'd0, a});
  endtask

  task automatic rbx(string tag, logic [7:0] exp, logic mnack);
    logic [7:0] v;
    logic s;
    exp_q.push_back('{tag, exp});
    for (int i = 7; i >= 0; i--) begin clk_bit(1'b1, s); v[i] = s; end
    clk_bit(mnack, s);
    obs_q.push_back(v);
  endtask

  function automatic logic [7:0] dev(logic [10:0] a, logic rnw);
    return {4'b1010, a[10:8], rnw};
  endfunction

  task automatic rand_read(string tag, logic [10:0] a);
    bus_start(); wbx(tag, dev(a, 1'b0), 1'b0); wbx(tag, a[7:0], 1'b0);
    bus_start(); wbx(tag, dev(a, 1'b1), 1'b0);
  endtask

  task automatic wait_idle(logic [10:0] a);
    logic ack;
    for (int k = 0; k < 40; k++) begin
      bus_start(); send_byte(dev(a, 1'b0), ack); bus_stop();
      if (!ack) break;
    end
  endtask

  task automatic report();
    waitc(4);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, got hung expected done");
    report();
  end

  initial begin
    logic ack;
    for (int i = 0; i < 2048; i++) mem[i] = 8'hFF;
    mem[11'h7FF] = 8'hA1;
    mem[11'h000] = 8'hB2;
    waitc(5);
    rst_n = 1'b1;
    waitc(5);
    // R3 reset state
    chk("R3", {7'd0, sda_oe}, 8'h00);
    chk("R7", {7'd0, busy}, 8'h00);
    chk("R5", {7'd0, wr_commit}, 8'h00);

    // R1 bits clocked without START get no acknowledge
    send_byte(8'hA0, ack);
    chk("R1", {7'd0, ack}, 8'h01);
    bus_stop();

    // R5 byte write at 0x123, then R7 busy polling
    bus_start();
    wbx("R2", dev(11'h123, 1'b0), 1'b0);
    wbx("R5", 8'h23, 1'b0);
    wbx("R5", 8'h5A, 1'b0);
    bus_stop();
    waitc(H);
    chk("R7", {7'd0, busy}, 8'h01);
    bus_start(); wbx("R7", dev(11'h123, 1'b0), 1'b1); bus_stop();
    wait_idle(11'h123);
    waitc(20);
    chk("R11", {7'd0, busy}, 8'h00);

    // R8 random read
    rand_read("R8", 11'h123); rbx("R8", 8'h5A, 1'b1); bus_stop();

    // R12 page wrap from 0x23E
    bus_start();
    wbx("R12", dev(11'h23E, 1'b0), 1'b0); wbx("R12", 8'h3E, 1'b0);
    wbx("R12", 8'h11, 1'b0); wbx("R12", 8'h22, 1'b0);
    wbx("R12", 8'h33, 1'b0); wbx("R12", 8'h44, 1'b0);
    bus_stop();
    wait_idle(11'h23E);
    rand_read("R9", 11'h23E);
    rbx("R9", 8'h11, 1'b0); rbx("R9", 8'h22, 1'b0); rbx("R12", 8'hFF, 1'b1); bus_stop();
    rand_read("R12", 11'h230);
    rbx("R12", 8'h33, 1'b0); rbx("R12", 8'h44, 1'b1); bus_stop();
    // R9 current address read continues at 0x232
    bus_start(); wbx("R9", dev(11'h232, 1'b1), 1'b0); rbx("R9", 8'hFF, 1'b1); bus_stop();

    // R10 wrap from 0x7FF to 0x000
    rand_read("R10", 11'h7FF);
    rbx("R10", 8'hA1, 1'b0); rbx("R10", 8'hB2, 1'b1); bus_stop();

    // R2 wrong device code
    bus_start(); wbx("R2", 8'hB0, 1'b1); bus_stop();
    chk("R2", {7'd0, sda_oe}, 8'h00);

    // R6 WP high at the strobe rejects the write
    wp = 1'b1;
    bus_start();
    wbx("R6", dev(11'h050, 1'b0), 1'b0); wbx("R6", 8'h50, 1'b0);
    wbx("R6", 8'h77, 1'b1);
    bus_stop();
    waitc(10);
    chk("R6", {7'd0, busy}, 8'h00);
    wp = 1'b0;
    rand_read("R6", 11'h050); rbx("R6", 8'hFF, 1'b1); bus_stop();

    // R6 WP raised after the first data byte has no effect
    bus_start();
    wbx("R6", dev(11'h060, 1'b0), 1'b0); wbx("R6", 8'h60, 1'b0);
    wbx("R6", 8'h61, 1'b0);
    wp = 1'b1;
    wbx("R6", 8'h62, 1'b0);
    bus_stop();
    wp = 1'b0;
    wait_idle(11'h060);
    rand_read("R6", 11'h060); rbx("R6", 8'h61, 1'b0); rbx("R6", 8'h62, 1'b1); bus_stop();

    // R11 repeated START discards accepted data
    bus_start();
    wbx("R11", dev(11'h070, 1'b0), 1'b0); wbx("R11", 8'h70, 1'b0);
    wbx("R11", 8'h99, 1'b0);
    bus_start(); wbx("R11", dev(11'h070, 1'b0), 1'b0);
    bus_stop();
    waitc(10);
    chk("R11", {7'd0, busy}, 8'h00);
    rand_read("R11", 11'h070); rbx("R11", 8'hFF, 1'b1); bus_stop();

    waitc(10);
    report();
  end
endmodule